// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is an SPI bus master for a small 16-bit peripheral register space. Software first programs one control register with several settings: the enable, the word length (8 or 16 bits), the clock polarity and phase, a 7-bit half-period divider and two interrupt masks. Writing the data register then sends one word, most significant bit first. The word received at the same time lands in a single-word buffer that software reads back from the same address. Chip selects are driven by separate general-purpose pins, so this block does not generate them.

The serial clock comes from the system clock. Each SCK half period lasts N+1 system cycles, where N is the divider field. A status register reports two flags: a word in flight, and an unread received word. One interrupt line combines a "received word waiting" source and a "ready for the next write" source, each with its own mask. Mode, length and divider are captured when a word starts, so software may reprogram them while a word is being shifted.

Top module: `spi_word_master`

## Requirements
- R1: After reset the control register (offset 0x2) and the status register (offset 0x4) both read 0. SCK is low and the interrupt output is low.
- R2: A full write to the data register (offset 0x0) starts one word only when control bit 0 (enable) is 1 and status bit 0 (busy) is 0. The write is ignored when the block is disabled: no SCK edge appears. A write made while busy does not change the word already being shifted.
- R3: Each SCK half period lasts N+1 system clock cycles, where N is control bits 15:9. The first edge comes N+1 cycles after the starting write. A word produces exactly 2×L SCK edges for a length of L bits.
- R4: SCK idles at the level of control bit 7 (CPOL). With control bit 8 (CPHA) at 0, MISO is sampled on the leading edge. With bit 8 at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Mode m sets bit 7 = m[1] and bit 8 = m[0].
- R5: Bits go out MSB first. With control bit 2 = 1 the word is 16 bits and bit 15 is sent first. With bit 2 = 0 only bits 7:0 are sent. A byte-wide data write (bus_byte = 1) supplies bits 7:0 and zeros above them.
- R6: The first received bit ends up in the most significant position of the word. An 8-bit word is read back zero-extended. A byte-wide read of the data register returns bits 7:0 zero-extended.
- R7: Status bit 1 (receive full) sets when a word completes. A full read of the data register clears it. A newer word replaces an unread one.
- R8: irq = (receive full AND control bit 5) OR (not busy AND enable AND control bit 6).
- R9: Clearing enable aborts a word in progress. Busy is 0 on the next cycle, SCK returns to its idle level and no received word is posted.
- R10: Changes made to the mode, length or divider fields during a word take effect only from the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on data register) |
| bus_byte | input | 1 | Byte-wide access to the data register |
| bus_addr | input | 3 | Byte offset: 0x0 data, 0x2 control, 0x4 status |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default 16-bit word and 7-bit divider. This lets it exercise both word lengths, all four clock modes, and dividers from 0 up to the largest value, 127, which gives a division ratio of 256. A behavioural SPI slave in the bench times every SCK edge against N+1. It also records MOSI and returns its own pattern on MISO.

Directed cases cover writes while disabled or busy, reprogramming control in the middle of a word, aborts, overwriting an unread word and byte accesses. Random transfers from a fixed seed then mix modes, lengths, dividers and data.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 7;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

    localparam int B_EN     = 0;
    localparam int B_WIDE   = 2;
    localparam int B_IE_RX  = 5;
    localparam int B_IE_TX  = 6;
    localparam int B_CPOL   = 7;
    localparam int B_CPHA   = 8;
    localparam int B_DIV_LO = 9;

    localparam logic [REG_W-1:0] CTL_MASK = 16'hFFE5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic             ie_tx;
        logic             ie_rx;
        logic             wide;
        logic             en;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [REG_W-1:0] r);
        ctl_t c;
        c.div   = r[B_DIV_LO +: DIV_W];
        c.cpha  = r[B_CPHA];
        c.cpol  = r[B_CPOL];
        c.ie_tx = r[B_IE_TX];
        c.ie_rx = r[B_IE_RX];
        c.wide  = r[B_WIDE];
        c.en    = r[B_EN];
        return c;
    endfunction
endpackage

// File: rtl/spiw_clkdiv.sv
module spiw_clkdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (!run)
            d.cnt = '0;
        else if (q.cnt == half_div)
            d.cnt = '0;
        else
            d.cnt = q.cnt + DIV_W'(1);
    end

    assign tick = run && (q.cnt == half_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= half_div));
endmodule

// File: rtl/spiw_shifter.sv
module spiw_shifter #(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              wide_in,
    input  logic              cpol_in,
    input  logic              cpha_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              miso,
    input  logic              tick,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DIV_W-1:0]  div_act,
    output logic [WORD_W-1:0] rx_word
);
    localparam int HALF_W = WORD_W / 2;
    localparam int EDGE_W = $clog2(2 * WORD_W);
    localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WORD_W - 1);
    localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(WORD_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              cpol;
        logic              cpha;
        logic              wide;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] edge_n;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } st_t;

    st_t  q, d;
    logic lead, do_sample, do_shift, last_edge;

    always_comb begin
        d         = q;
        done      = 1'b0;
        lead      = ~q.edge_n[0];
        do_sample = lead ^ q.cpha;
        do_shift  = q.cpha ? (lead && (q.edge_n != '0)) : !lead;
        last_edge = q.edge_n == (q.wide ? LAST_WIDE : LAST_NARROW);
        if (!enable) begin
            d.busy = 1'b0;
            d.sck  = cpol_in;
        end else if (!q.busy) begin
            d.sck = cpol_in;
            if (start) begin
                d.busy   = 1'b1;
                d.edge_n = '0;
                d.cpol   = cpol_in;
                d.cpha   = cpha_in;
                d.wide   = wide_in;
                d.div    = div_in;
                d.rx     = '0;
                d.tx     = wide_in ? word_in
                                   : {word_in[HALF_W-1:0], {HALF_W{1'b0}}};
            end
        end else if (tick) begin
            d.sck    = ~q.sck;
            d.edge_n = q.edge_n + EDGE_W'(1);
            if (do_sample)
                d.rx = {q.rx[WORD_W-2:0], miso};
            if (do_shift)
                d.tx = {q.tx[WORD_W-2:0], 1'b0};
            if (last_edge) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end
        end
    end

    assign busy    = q.busy;
    assign sck     = q.sck;
    assign mosi    = q.tx[WORD_W-1];
    assign div_act = q.div;
    assign rx_word = q.wide ? d.rx : {{HALF_W{1'b0}}, d.rx[HALF_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    // R3
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && enable && !tick) |=> $stable(q.sck));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $past(q.busy)) |->
            ($stable(q.div) && $stable(q.cpha) && $stable(q.cpol) && $stable(q.wide)));

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !$past(q.busy) && $stable(cpol_in)) |-> (q.sck == cpol_in));
endmodule

// File: rtl/spiw_regs.sv
module spiw_regs
    import spiw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rx,
    output logic [WORD_W-1:0] bus_rdata,
    output ctl_t              ctl,
    output logic              start,
    output logic [WORD_W-1:0] tx_word,
    output logic              irq
);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] rx;
        logic              full;
    } st_t;

    st_t  q, d;
    logic hit_data, hit_ctl;

    assign ctl      = ctl_decode(q.ctl);
    assign hit_data = bus_addr == OFS_DATA;
    assign hit_ctl  = bus_addr == OFS_CTL;

    always_comb begin
        d = q;
        if (bus_wr && hit_ctl)
            d.ctl = bus_wdata & CTL_MASK;
        if (eng_done) begin
            d.rx   = eng_rx;
            d.full = 1'b1;
        end else if (bus_rd && hit_data && !bus_byte) begin
            d.full = 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = bus_byte ? {{HALF_W{1'b0}}, q.rx[HALF_W-1:0]} : q.rx;
            OFS_CTL:  bus_rdata = q.ctl;
            OFS_STAT: bus_rdata = WORD_W'({q.full, eng_busy});
            default:  bus_rdata = '0;
        endcase
    end

    assign start   = bus_wr && hit_data && ctl.en && !eng_busy;
    assign tx_word = bus_byte ? {{HALF_W{1'b0}}, bus_wdata[HALF_W-1:0]} : bus_wdata;
    assign irq     = (q.full && ctl.ie_rx) || (!eng_busy && ctl.en && ctl.ie_tx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> q.full);

    // R7
    full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> $past(eng_done));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spiw_pkg::*;
#(
    parameter int WORD_W = spiw_pkg::REG_W,
    parameter int DIV_W  = spiw_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_byte,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    ctl_t              ctl;
    logic              start, busy, done, tick;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic [DIV_W-1:0]  div_act;

    spiw_regs #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .eng_busy  (busy),
        .eng_done  (done),
        .eng_rx    (rx_word),
        .bus_rdata (bus_rdata),
        .ctl       (ctl),
        .start     (start),
        .tx_word   (tx_word),
        .irq       (irq)
    );

    spiw_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_div (div_act),
        .tick     (tick)
    );

    spiw_shifter #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctl.en),
        .start   (start),
        .wide_in (ctl.wide),
        .cpol_in (ctl.cpol),
        .cpha_in (ctl.cpha),
        .div_in  (ctl.div),
        .word_in (tx_word),
        .miso    (miso),
        .tick    (tick),
        .busy    (busy),
        .sck     (sck),
        .mosi    (mosi),
        .done    (done),
        .div_act (div_act),
        .rx_word (rx_word)
    );
endmodule

// File: tb/spi_word_master_bench.sv
module spi_word_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_DATA = 3'h0, A_CTL = 3'h2, A_STAT = 3'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, bsel = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    bit          sl_on = 0, sl_cpol = 0, sl_cpha = 0;
    int          sl_nb = 8, sl_oi = 0, sl_edges = 0, sl_half = 1, sl_bad = 0, sl_last = 0;
    logic [15:0] sl_tx = '0, sl_got = '0;
    logic [15:0] ex_tx = '0, ex_rx = '0;

    spi_word_master u_spi_word_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_byte(bsel),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // behavioural slave
    always @(sck) begin
        if (sl_on) begin
            sl_edges++;
            if (cyc - sl_last != sl_half) sl_bad++;
            sl_last = cyc;
            if (sck != sl_cpol) begin
                if (!sl_cpha) sl_got = {sl_got[14:0], mosi};
                else begin
                    if (sl_oi < sl_nb) miso = sl_tx[sl_nb-1-sl_oi];
                    sl_oi++;
                end
            end else begin
                if (sl_cpha) sl_got = {sl_got[14:0], mosi};
                else begin
                    if (sl_oi < sl_nb) miso = sl_tx[sl_nb-1-sl_oi];
                    sl_oi++;
                end
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctlw(input bit en, input bit wide, input bit ierx,
                                         input bit ietx, input bit cpol, input bit cpha,
                                         input int dv);
        return 16'(en) | (16'(wide) << 2) | (16'(ierx) << 5) | (16'(ietx) << 6) |
               (16'(cpol) << 7) | (16'(cpha) << 8) | (16'(dv & 127) << 9);
    endfunction

    function automatic logic [15:0] fit(input bit wide, input logic [15:0] v);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] v, input bit b);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = v; bsel = b;
        @(negedge clk);
        wr = 1'b0; bsel = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input bit b, output logic [15:0] v);
        @(negedge clk);
        rd = 1'b1; addr = a; bsel = b;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0; bsel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_start(input int mode, input bit wide, input int dv,
                              input logic [15:0] txw, input logic [15:0] slw,
                              input bit ierx, input bit ietx, input bit b);
        sl_on   = 0;
        sl_cpol = mode[1];
        sl_cpha = mode[0];
        sl_nb   = wide ? 16 : 8;
        sl_tx   = fit(wide, slw);
        sl_got  = '0;
        sl_edges = 0;
        sl_bad  = 0;
        sl_half = dv + 1;
        ex_tx   = fit(wide, b ? {8'h00, txw[7:0]} : txw);
        ex_rx   = fit(wide, slw);
        bus_wr(A_CTL, ctlw(1, wide, ierx, ietx, mode[1], mode[0], dv), 0);
        if (!sl_cpha) begin miso = sl_tx[sl_nb-1]; sl_oi = 1; end
        else          begin miso = 1'b0;           sl_oi = 0; end
        bus_wr(A_DATA, txw, b);
        sl_last = cyc;
        sl_on   = 1;
    endtask

    task automatic xfer_finish(input bit do_read);
        logic [15:0] v;
        v = '1;
        for (int i = 0; i < 6000; i++) begin
            bus_rd(A_STAT, 0, v);
            if (!v[0]) break;
        end
        chk("R2 word completes", 32'(v[0]), 0);
        chk("R5 mosi bits", 32'(sl_got), 32'(ex_tx));
        chk("R3 edge count", sl_edges, 2 * sl_nb);
        chk("R3 half period", sl_bad, 0);
        chk("R4 idle level", 32'(sck), 32'(sl_cpol));
        chk("R7 rx full set", 32'(v[1]), 1);
        sl_on = 0;
        if (do_read) begin
            bus_rd(A_DATA, 0, v);
            chk("R6 rx word", 32'(v), 32'(ex_rx));
            bus_rd(A_STAT, 0, v);
            chk("R7 full cleared", 32'(v[1]), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        bus_rd(A_CTL, 0, v);  chk("R1 ctl reset", 32'(v), 0);
        bus_rd(A_STAT, 0, v); chk("R1 stat reset", 32'(v), 0);
        chk("R1 sck reset", 32'(sck), 0);
        chk("R1 irq reset", 32'(irq), 0);

        // R2 write while disabled
        bus_wr(A_CTL, ctlw(0, 1, 0, 0, 0, 0, 0), 0);
        sl_on = 1; sl_edges = 0; sl_last = cyc; sl_half = 1;
        bus_wr(A_DATA, 16'h1234, 0);
        wait_cyc(40);
        bus_rd(A_STAT, 0, v);
        chk("R2 disabled no busy", 32'(v[0]), 0);
        chk("R2 disabled no edges", sl_edges, 0);
        sl_on = 0;

        // R4 R5 R6 all modes, both lengths
        for (int m = 0; m < 4; m++) begin
            xfer_start(m, 1, 1, 16'hA51E ^ 16'(m), 16'h3C96 + 16'(m), 0, 0, 0);
            xfer_finish(1);
            xfer_start(m, 0, 2, 16'hFF81 + 16'(m), 16'h005A ^ 16'(m), 0, 0, 0);
            xfer_finish(1);
        end

        // R2 write while busy is ignored
        xfer_start(0, 1, 3, 16'hC3A5, 16'h0F0F, 0, 0, 0);
        wait_cyc(4);
        bus_wr(A_DATA, 16'h5A5A, 0);
        xfer_finish(1);

        // R10 reprogram mid-word (cpol kept)
        xfer_start(1, 1, 2, 16'h9E37, 16'h7101, 0, 0, 0);
        wait_cyc(6);
        bus_wr(A_CTL, ctlw(1, 0, 0, 0, 0, 0, 0), 0);
        xfer_finish(1);
        xfer_start(0, 0, 0, 16'h00B4, 16'h00D2, 0, 0, 0);
        xfer_finish(1);

        // R7 overwrite of unread word
        xfer_start(0, 0, 0, 16'h0011, 16'h0033, 0, 0, 0);
        xfer_finish(0);
        xfer_start(0, 0, 0, 16'h0022, 16'h0044, 0, 0, 0);
        xfer_finish(0);
        bus_rd(A_DATA, 0, v);
        chk("R7 overwrite keeps newest", 32'(v), 32'h0044);

        // R8 interrupt sources
        bus_wr(A_CTL, ctlw(1, 0, 0, 1, 0, 0, 0), 0);
        wait_cyc(1);
        chk("R8 irq write-ready", 32'(irq), 1);
        bus_wr(A_CTL, ctlw(0, 0, 0, 1, 0, 0, 0), 0);
        wait_cyc(1);
        chk("R8 irq off when disabled", 32'(irq), 0);
        xfer_start(0, 1, 3, 16'h1111, 16'h2222, 0, 1, 0);
        wait_cyc(3);
        chk("R8 irq low while busy", 32'(irq), 0);
        xfer_finish(1);
        xfer_start(0, 0, 1, 16'h0077, 16'h0066, 1, 0, 0);
        xfer_finish(0);
        wait_cyc(1);
        chk("R8 irq on rx full", 32'(irq), 1);
        bus_rd(A_DATA, 0, v);
        wait_cyc(1);
        chk("R8 irq cleared by read", 32'(irq), 0);

        // R9 abort
        xfer_start(3, 1, 7, 16'hDEAD, 16'hBEEF, 0, 0, 0);
        wait_cyc(20);
        sl_on = 0;
        bus_wr(A_CTL, ctlw(0, 1, 0, 0, 1, 1, 7), 0);
        bus_rd(A_STAT, 0, v);
        chk("R9 abort busy low", 32'(v[0]), 0);
        chk("R9 abort no rx word", 32'(v[1]), 0);
        chk("R9 abort sck idle", 32'(sck), 1);
        bus_wr(A_CTL, ctlw(0, 1, 0, 0, 0, 0, 0), 0);
        wait_cyc(2);

        // R5 byte-wide data write
        xfer_start(0, 1, 1, 16'hA5C3, 16'h1357, 0, 0, 1);
        xfer_finish(1);

        // R6 byte-wide read
        xfer_start(2, 1, 0, 16'h2468, 16'hBEEF, 0, 0, 0);
        xfer_finish(0);
        bus_rd(A_DATA, 1, v);
        chk("R6 byte read", 32'(v), 32'h00EF);
        bus_rd(A_DATA, 0, v);

        // R3 largest divider
        xfer_start(1, 0, 127, 16'h00C9, 16'h0036, 0, 0, 0);
        xfer_finish(1);

        // random mix
        for (int k = 0; k < 40; k++) begin
            int          m, dv;
            bit          w;
            logic [15:0] t, s;
            m  = int'($urandom_range(3, 0));
            dv = int'($urandom_range(7, 0));
            w  = 1'($urandom_range(1, 0));
            t  = 16'($urandom());
            s  = 16'($urandom());
            xfer_start(m, w, dv, t, s, 0, 0, 0);
            xfer_finish(1);
        end

        summary();
    end
endmodule